// File: doc/BRIEF.md
# Reset Sequencer with Boot Fetch

This block sits between the reset sources of a small microcontroller and its CPU core. It accepts four reset causes: power-on (the block's own asynchronous reset), a level-sensitive external reset request, a watchdog pulse and a software pulse. Whatever the cause, it holds the core in reset.

An oscillator stabilization delay is inserted only when one of two conditions holds. Either the sequence began at power-on, or a cause arrived while the device's stop-mode flag was high. The block then performs two reads through a plain request/valid ROM port. The first read takes a mode word, selected by the mode pins. The second takes the reset vector.

When both reads are complete, the block releases the core. It presents the start address taken from the vector together with a one-cycle start pulse. A one-hot cause register reports which cause produced the most recent reset. Any new cause arriving mid-sequence sends the block back to its holding state. No RAM-held value is relied on at any point.

Top module: `rsq_reset_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after, `core_rst` is 1, `rom_req` is 0, `start_pulse` is 0 and `rst_cause` is 4'b0001.
- R2: `rst_cause` is one-hot, with the following encoding: bit 0 power-on, bit 1 external, bit 2 watchdog, bit 3 software. It is loaded on the clock edge that sees a cause. When causes coincide, the priority is external, then watchdog, then software. The value is kept until the next cause.
- R3: Power-on, or a cause seen while `stop_flag` is 1, makes the block spend exactly `WAIT_CYCLES` cycles in the stabilization wait after the holding cycle. Without either condition, the mode read request starts on the cycle after the holding cycle.
- R4: While `ext_rst_req` is 1, `core_rst` stays 1 and `rom_req` stays 0 from the next cycle on.
- R5: The mode read drives `rom_addr = MODE_BASE + mode pins`, where the pins are those sampled on the last holding cycle. `rom_req` is held with a stable address until `rom_valid`, and the data is then presented on `boot_mode`.
- R6: After the mode read, a read of address `VEC_ADDR` is issued. Bits [AW-1:0] of its data become `start_addr`.
- R7: On the cycle after the vector read completes, `core_rst` falls and `start_pulse` is 1 for exactly that one cycle.
- R8: A watchdog, software or external cause in any state returns the block to holding on the next cycle. This drops `rom_req` and asserts `core_rst`, and the fetch restarts from the mode read.
- R9: A pending stabilization requirement survives an abort. A cause arriving during the wait restarts a full wait even when `stop_flag` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| ext_rst_req | input | 1 | External reset request, level |
| wdt_rst_pls | input | 1 | Watchdog reset, one-cycle pulse |
| sw_rst_pls | input | 1 | Software reset, one-cycle pulse |
| mode_pins | input | MODE_W | Mode pin levels that select the mode word |
| stop_flag | input | 1 | Device is in stop mode |
| rom_req | output | 1 | ROM read request |
| rom_addr | output | AW | ROM read address (0 when idle) |
| rom_valid | input | 1 | ROM data valid for the current request |
| rom_rdata | input | DW | ROM read data |
| core_rst | output | 1 | Reset held on the CPU core |
| start_pulse | output | 1 | One-cycle pulse when the core is released |
| start_addr | output | AW | Start address taken from the vector |
| boot_mode | output | DW | Captured mode word |
| rst_cause | output | 4 | One-hot record of the last reset cause |

## Verification
A wrong sequencer state shows at the ports on the very next cycle. The block would release `core_rst` early, assert `rom_req` during holding or waiting, or drive the wrong `rom_addr`; all of these outputs are decoded from registered state with no input path. A wrong wait count moves the first cycle of `rom_req` by the error, so the stabilization length is measured from the edge that sees the cause. A lost stabilization requirement after an abort appears as a mode read that starts `WAIT_CYCLES` cycles too early.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   typedef enum logic [2:0] {
      ST_HOLD = 3'd0,
      ST_STAB = 3'd1,
      ST_MODE = 3'd2,
      ST_VEC  = 3'd3,
      ST_RUN  = 3'd4
   } seq_state_e;

   localparam int CAUSE_N   = 4;
   localparam int CAUSE_POR = 0;
   localparam int CAUSE_EXT = 1;
   localparam int CAUSE_WDT = 2;
   localparam int CAUSE_SW  = 3;

endpackage

// File: rtl/rsq_cause_unit.sv
module rsq_cause_unit #(
   parameter int N       = 4,
   parameter int RST_BIT = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic         any,
   output logic [N-1:0] status
);
   generate
      if (N < 2) begin : g_bad_n
         $error("rsq_cause_unit: N must be at least 2");
      end
      if (RST_BIT < 0 || RST_BIT >= N) begin : g_bad_bit
         $error("rsq_cause_unit: RST_BIT out of range");
      end
   endgenerate

   localparam logic [N-1:0] RST_ONEHOT = N'(1) << RST_BIT;

   logic [N-1:0] pick;

   // lowest index wins: scan downward so the last write is the lowest set bit
   always_comb begin
      pick = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            pick    = '0;
            pick[i] = 1'b1;
         end
      end
   end

   assign any = |req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= RST_ONEHOT;
      end else if (any) begin
         status <= pick;
      end
   end
endmodule

// File: rtl/rsq_stab_timer.sv
module rsq_stab_timer #(
   parameter int CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   generate
      if (CYCLES < 1) begin : g_bad
         $error("rsq_stab_timer: CYCLES must be at least 1");
      end

      if (CYCLES == 1) begin : g_single
         assign done = run;
      end else begin : g_count
         localparam int CW = $clog2(CYCLES);
         localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run) begin
               cnt <= '0;
            end else if (cnt != LAST) begin
               cnt <= cnt + 1'b1;
            end
         end

         assign done = run && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/rsq_rom_fetch.sv
module rsq_rom_fetch #(
   parameter int AW        = 12,
   parameter int DW        = 16,
   parameter int MODE_W    = 2,
   parameter int MODE_BASE = 0,
   parameter int VEC_ADDR  = 4094
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_mode,
   input  logic              in_vec,
   input  logic              abort,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic              rom_valid,
   input  logic [DW-1:0]     rom_rdata,
   output logic              rom_req,
   output logic [AW-1:0]     rom_addr,
   output logic [DW-1:0]     mode_word,
   output logic [AW-1:0]     vec_word
);
   generate
      if (DW < AW) begin : g_bad_dw
         $error("rsq_rom_fetch: DW must be at least AW");
      end
      if (MODE_W > AW) begin : g_bad_mw
         $error("rsq_rom_fetch: MODE_W must not exceed AW");
      end
   endgenerate

   localparam logic [AW-1:0] BASE_A = AW'(MODE_BASE);
   localparam logic [AW-1:0] VEC_A  = AW'(VEC_ADDR);

   logic take_mode;
   logic take_vec;

   assign rom_req   = in_mode | in_vec;
   assign take_mode = in_mode && rom_valid && !abort;
   assign take_vec  = in_vec  && rom_valid && !abort;

   always_comb begin
      rom_addr = '0;
      if (in_mode) begin
         rom_addr = BASE_A + AW'(mode_sel);
      end else if (in_vec) begin
         rom_addr = VEC_A;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_word <= '0;
         vec_word  <= '0;
      end else begin
         if (take_mode) begin
            mode_word <= rom_rdata;
         end
         if (take_vec) begin
            vec_word <= rom_rdata[AW-1:0];
         end
      end
   end
endmodule

// File: rtl/rsq_reset_seq.sv
module rsq_reset_seq #(
   parameter int AW          = 12,
   parameter int DW          = 16,
   parameter int MODE_W      = 2,
   parameter int WAIT_CYCLES = 64,
   parameter int MODE_BASE   = 16,
   parameter int VEC_ADDR    = 4094
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_rst_req,
   input  logic              wdt_rst_pls,
   input  logic              sw_rst_pls,
   input  logic [MODE_W-1:0] mode_pins,
   input  logic              stop_flag,
   output logic              rom_req,
   output logic [AW-1:0]     rom_addr,
   input  logic              rom_valid,
   input  logic [DW-1:0]     rom_rdata,
   output logic              core_rst,
   output logic              start_pulse,
   output logic [AW-1:0]     start_addr,
   output logic [DW-1:0]     boot_mode,
   output logic [3:0]        rst_cause
);
   import rsq_pkg::*;

   generate
      if (CAUSE_N != 4) begin : g_bad_n
         $error("rsq_reset_seq: cause count must be 4");
      end
      if (MODE_BASE < 0 || MODE_BASE + (1 << MODE_W) > (1 << AW)) begin : g_bad_base
         $error("rsq_reset_seq: mode table does not fit the address space");
      end
      if (VEC_ADDR < 0 || VEC_ADDR >= (1 << AW)) begin : g_bad_vec
         $error("rsq_reset_seq: VEC_ADDR out of range");
      end
   endgenerate

   seq_state_e        state;
   logic              need_wait;
   logic [MODE_W-1:0] mode_sel;
   logic              cause_any;
   logic [3:0]        cause_req;
   logic              stab_run;
   logic              stab_done;

   // power-on is the asynchronous reset itself, so its request bit stays low
   always_comb begin
      cause_req            = '0;
      cause_req[CAUSE_EXT] = ext_rst_req;
      cause_req[CAUSE_WDT] = wdt_rst_pls;
      cause_req[CAUSE_SW]  = sw_rst_pls;
   end

   rsq_cause_unit #(
      .N       (CAUSE_N),
      .RST_BIT (CAUSE_POR)
   ) u_cause (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (cause_req),
      .any    (cause_any),
      .status (rst_cause)
   );

   assign stab_run = (state == ST_STAB) && !cause_any;

   rsq_stab_timer #(
      .CYCLES (WAIT_CYCLES)
   ) u_stab (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (stab_run),
      .done  (stab_done)
   );

   rsq_rom_fetch #(
      .AW        (AW),
      .DW        (DW),
      .MODE_W    (MODE_W),
      .MODE_BASE (MODE_BASE),
      .VEC_ADDR  (VEC_ADDR)
   ) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_mode   (state == ST_MODE),
      .in_vec    (state == ST_VEC),
      .abort     (cause_any),
      .mode_sel  (mode_sel),
      .rom_valid (rom_valid),
      .rom_rdata (rom_rdata),
      .rom_req   (rom_req),
      .rom_addr  (rom_addr),
      .mode_word (boot_mode),
      .vec_word  (start_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_HOLD;
         need_wait   <= 1'b1;
         mode_sel    <= '0;
         start_pulse <= 1'b0;
      end else begin
         start_pulse <= 1'b0;
         if (state == ST_HOLD) begin
            mode_sel <= mode_pins;
         end
         if (cause_any) begin
            state     <= ST_HOLD;
            need_wait <= need_wait | stop_flag;
         end else begin
            case (state)
               ST_HOLD: state <= need_wait ? ST_STAB : ST_MODE;
               ST_STAB: begin
                  if (stab_done) begin
                     state     <= ST_MODE;
                     need_wait <= 1'b0;
                  end
               end
               ST_MODE: begin
                  if (rom_valid) begin
                     state <= ST_VEC;
                  end
               end
               ST_VEC: begin
                  if (rom_valid) begin
                     state       <= ST_RUN;
                     start_pulse <= 1'b1;
                  end
               end
               default: state <= state;
            endcase
         end
      end
   end

   assign core_rst = (state != ST_RUN);
endmodule

// File: rtl/rsq_reset_seq_chk.sv
module rsq_reset_seq_chk #(
   parameter int AW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ext_rst_req,
   input logic          wdt_rst_pls,
   input logic          sw_rst_pls,
   input logic          rom_req,
   input logic          rom_valid,
   input logic [AW-1:0] rom_addr,
   input logic          core_rst,
   input logic          start_pulse,
   input logic [3:0]    rst_cause
);
   always_comb begin
      if (!rst_n) begin
         assert_reset_hold_R1: assert (core_rst && !rom_req && !start_pulse);
      end
   end

   assert_cause_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rst_cause) == 1);

   assert_ext_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rst_req |=> (core_rst && !rom_req));

   assert_fetch_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_req && !rom_valid && !ext_rst_req && !wdt_rst_pls && !sw_rst_pls)
      |=> (rom_req && $stable(rom_addr)));

   assert_release_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst) |-> start_pulse);

   assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);

   assert_pulse_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> !core_rst);

   assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_rst_pls || sw_rst_pls) |=> (core_rst && !rom_req));
endmodule

bind rsq_reset_seq rsq_reset_seq_chk #(
   .AW (AW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ext_rst_req (ext_rst_req),
   .wdt_rst_pls (wdt_rst_pls),
   .sw_rst_pls  (sw_rst_pls),
   .rom_req     (rom_req),
   .rom_valid   (rom_valid),
   .rom_addr    (rom_addr),
   .core_rst    (core_rst),
   .start_pulse (start_pulse),
   .rst_cause   (rst_cause)
);

// File: tb/tb_rsq_reset_seq.sv
`timescale 1ns/1ps
module tb_rsq_reset_seq;
   localparam int AW = 12;
   localparam int DW = 16;
   localparam int MW = 2;
   localparam int WC = 6;
   localparam int MB = 16;
   localparam int VA = 4094;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ext_rst_req, wdt_rst_pls, sw_rst_pls, stop_flag;
   logic [MW-1:0] mode_pins;
   logic          rom_req, rom_valid;
   logic [AW-1:0] rom_addr;
   logic [DW-1:0] rom_rdata;
   logic          core_rst, start_pulse;
   logic [AW-1:0] start_addr;
   logic [DW-1:0] boot_mode;
   logic [3:0]    rst_cause;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   int rom_lat = 1;
   int lat_cnt = 0;

   always #4 clk = ~clk;

   rsq_reset_seq #(.AW(AW), .DW(DW), .MODE_W(MW), .WAIT_CYCLES(WC),
                   .MODE_BASE(MB), .VEC_ADDR(VA)) dut (
      .clk(clk), .rst_n(rst_n), .ext_rst_req(ext_rst_req),
      .wdt_rst_pls(wdt_rst_pls), .sw_rst_pls(sw_rst_pls),
      .mode_pins(mode_pins), .stop_flag(stop_flag),
      .rom_req(rom_req), .rom_addr(rom_addr), .rom_valid(rom_valid),
      .rom_rdata(rom_rdata), .core_rst(core_rst), .start_pulse(start_pulse),
      .start_addr(start_addr), .boot_mode(boot_mode), .rst_cause(rst_cause));

   function automatic logic [DW-1:0] romf(input logic [AW-1:0] a);
      return 16'h5A3C ^ (16'(a) * 16'd37);
   endfunction

   // ROM responder: valid after rom_lat waiting cycles, one cycle wide
   always @(negedge clk) begin
      if (!rst_n) begin
         rom_valid = 1'b0;
         lat_cnt = 0;
      end else if (rom_valid) begin
         rom_valid = 1'b0;
         lat_cnt = 0;
      end else if (rom_req) begin
         if (lat_cnt >= rom_lat) begin
            rom_valid = 1'b1;
            rom_rdata = romf(rom_addr);
         end else begin
            lat_cnt++;
         end
      end else begin
         lat_cnt = 0;
      end
   end

   // behavioural reference: 0 hold, 1 wait, 2 mode read, 3 vector read, 4 run
   int           m_st;
   int           m_cnt;
   bit           m_need;
   bit           m_pulse;
   logic [3:0]   m_cause;
   logic [MW-1:0] m_msel;
   logic [DW-1:0] m_mode;
   logic [AW-1:0] m_pc;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st <= 0; m_cnt <= 0; m_need <= 1; m_pulse <= 0;
         m_cause <= 4'b0001; m_msel <= '0; m_mode <= '0; m_pc <= '0;
      end else begin
         m_pulse <= 0;
         if (m_st == 0) m_msel <= mode_pins;
         if (ext_rst_req || wdt_rst_pls || sw_rst_pls) begin
            m_st <= 0;
            m_cnt <= 0;
            m_need <= m_need | stop_flag;
            m_cause <= ext_rst_req ? 4'b0010 : (wdt_rst_pls ? 4'b0100 : 4'b1000);
         end else if (m_st == 0) begin
            m_st <= m_need ? 1 : 2;
            m_cnt <= 0;
         end else if (m_st == 1) begin
            if (m_cnt == WC - 1) begin
               m_st <= 2; m_need <= 0; m_cnt <= 0;
            end else m_cnt <= m_cnt + 1;
         end else if (m_st == 2 && rom_valid) begin
            m_mode <= rom_rdata; m_st <= 3;
         end else if (m_st == 3 && rom_valid) begin
            m_pc <= rom_rdata[AW-1:0]; m_st <= 4; m_pulse <= 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      logic [AW-1:0] e_addr;
      e_addr = (m_st == 2) ? AW'(MB + int'(m_msel)) : ((m_st == 3) ? AW'(VA) : '0);
      chk(core_rst == (m_st != 4), "R7 core_rst", core_rst, m_st != 4);
      chk(rom_req == (m_st == 2 || m_st == 3), "R5 rom_req", rom_req, m_st == 2 || m_st == 3);
      chk(rom_addr == e_addr, "R6 rom_addr", rom_addr, e_addr);
      chk(start_pulse == m_pulse, "R7 start_pulse", start_pulse, m_pulse);
      chk(rst_cause == m_cause, "R2 rst_cause", rst_cause, m_cause);
      chk(boot_mode == m_mode, "R5 boot_mode", boot_mode, m_mode);
      chk(start_addr == m_pc, "R6 start_addr", start_addr, m_pc);
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
         finish_run();
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_run(input string tag);
      int k;
      k = 0;
      while (!start_pulse && k < 300) begin
         @(negedge clk);
         k++;
      end
      chk(start_pulse == 1'b1, tag, start_pulse, 1);
   endtask

   task automatic pulse(input bit e, input bit w, input bit s);
      ext_rst_req = e; wdt_rst_pls = w; sw_rst_pls = s;
      @(negedge clk);
      ext_rst_req = 0; wdt_rst_pls = 0; sw_rst_pls = 0;
   endtask

   initial begin
      rst_n = 0; ext_rst_req = 0; wdt_rst_pls = 0; sw_rst_pls = 0;
      stop_flag = 0; mode_pins = 2'd1; rom_valid = 0; rom_rdata = '0;
      tick(3);
      // R1: reset state
      chk(core_rst && !rom_req && !start_pulse && rst_cause == 4'b0001,
          "R1 reset state", {core_rst, rom_req, start_pulse, rst_cause}, 7'b1000001);
      rst_n = 1;
      // R3: power-on wait of WC cycles
      tick(WC);
      chk(rom_req == 1'b0, "R3 still waiting", rom_req, 0);
      tick(1);
      chk(rom_req == 1'b1, "R3 mode read after wait", rom_req, 1);
      chk(rom_addr == AW'(MB + 1), "R5 mode address", rom_addr, MB + 1);
      wait_run("R7 first release");
      chk(start_addr == romf(AW'(VA)) % (1 << AW), "R6 start address", start_addr, romf(AW'(VA)) % (1 << AW));
      chk(boot_mode == romf(AW'(MB + 1)), "R5 mode word", boot_mode, romf(AW'(MB + 1)));
      chk(core_rst == 1'b0, "R7 released", core_rst, 0);
      tick(1);
      chk(start_pulse == 1'b0, "R7 pulse one cycle", start_pulse, 0);

      // software reset without stop: no wait
      rom_lat = 0;
      pulse(0, 0, 1);
      chk(core_rst && rst_cause == 4'b1000, "R2 software cause", rst_cause, 4'b1000);
      tick(1);
      chk(rom_req == 1'b1, "R3 no wait", rom_req, 1);
      wait_run("R7 after software");

      // watchdog during stop: wait applied
      stop_flag = 1;
      pulse(0, 1, 0);
      stop_flag = 0;
      chk(rst_cause == 4'b0100, "R2 watchdog cause", rst_cause, 4'b0100);
      tick(WC);
      chk(rom_req == 1'b0, "R3 stop wait", rom_req, 0);
      tick(1);
      chk(rom_req == 1'b1, "R3 stop wait end", rom_req, 1);
      wait_run("R7 after watchdog");

      // external reset held, mode pins changed
      mode_pins = 2'd3;
      ext_rst_req = 1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(core_rst && !rom_req, "R4 held in reset", {core_rst, rom_req}, 2'b10);
      end
      ext_rst_req = 0;
      tick(1);
      chk(rom_addr == AW'(MB + 3), "R5 new mode address", rom_addr, MB + 3);
      wait_run("R7 after external");
      chk(boot_mode == romf(AW'(MB + 3)), "R5 mode word pins 3", boot_mode, romf(AW'(MB + 3)));

      // abort during mode read
      rom_lat = 4;
      pulse(0, 0, 1);
      tick(2);
      chk(rom_req == 1'b1, "R8 mode read active", rom_req, 1);
      pulse(0, 1, 0);
      chk(core_rst && !rom_req && rst_cause == 4'b0100, "R8 abort",
          {core_rst, rom_req, rst_cause}, 6'b100100);
      tick(1);
      chk(rom_addr == AW'(MB + 3), "R8 restart at mode read", rom_addr, MB + 3);
      rom_lat = 1;
      wait_run("R8 completes");

      // simultaneous causes
      pulse(1, 0, 1);
      chk(rst_cause == 4'b0010, "R2 priority", rst_cause, 4'b0010);
      wait_run("R2 recovery");

      // sticky wait across abort
      stop_flag = 1;
      pulse(0, 0, 1);
      stop_flag = 0;
      tick(3);
      pulse(0, 1, 0);
      tick(WC);
      chk(rom_req == 1'b0, "R9 full wait after abort", rom_req, 0);
      tick(1);
      chk(rom_req == 1'b1, "R9 wait end", rom_req, 1);
      wait_run("R9 release");
      tick(2);
      finish_run();
   end
endmodule